// File: doc/BRIEF.md
# Banked Channel Register File for a Descriptor DMA Engine

This block is the software-visible register file of a multi-channel descriptor DMA engine. The bus is a simple 32-bit memory-mapped one. Writes are strobed and take effect at the clock edge. Reads are combinational from the address. Twenty channels share one window of private registers. A channel-select register decides which channel's copy that window reaches. A second select register does the same for a small bank of per-port control words.

Each channel keeps the following state:
- an enable, a direction flag and a two-bit arbitration weight;
- a self-timed channel reset;
- polling settings;
- a descriptor ring base and a descriptor ring length;
- six interrupt status bits and six interrupt enable bits.

The enable, direction, weight and reset are driven straight to the datapath. Per-channel event inputs set the status bits, and software clears them by writing ones. A global per-channel enable gates each channel's enabled status onto one shared interrupt line. A global control write resets the whole bank.

Top module: `dmacsr_bank`

## Requirements
- R1: After reset, every channel and port register reads zero, ch_on, ch_rst, ch_tx, ch_weight and irq are zero, and both select registers are zero.
- R2: Address 0x08 is read-only and returns {channel count [31:20], port count [19:16], revision [4:0]}, which is 0x01440003 with the default parameters.
- R3: The channel selector at 0x18 decides which channel the registers at 0x14..0x2C read and write. Each channel keeps its own copy. A write of a channel number of 20 or more leaves the selector unchanged.
- R4: Channel control at 0x1C holds on (bit 0), reset (bit 1), transmit direction (bit 8) and weight (bits 17:16). It drives ch_on, ch_tx and ch_weight[2n+1:2n] for channel n.
- R5: Writing 1 to bit 1 of channel control raises ch_rst for that channel for exactly 8 cycles. Bit 1 reads 1 for that time, and then ch_rst clears by itself.
- R6: While a channel reset is active, that channel's ch_on is 0. Its status bits are held at zero, and status events for that channel are ignored.
- R7: The status register at 0x28 has bits 6:1. Input ch_evt[6n+k-1] sets bit k of channel n. Writing a 1 to a bit clears it, and writing 0x7E clears all of them. An event and a clear in the same cycle leave the bit set.
- R8: irq is high when some channel n has bit n set in the global enable at 0xF4 and has a status bit set whose enable bit in the channel enable register at 0x2C (bits 6:1) is also set.
- R9: The poll register at 0x14 keeps only bit 31 (polling on) and bit 6 (clock divide by 4). Its other bits read zero.
- R10: The port selector at 0x40 decides which port's control word appears at 0x44. That word keeps only bits 11:8, 6 and 5:2, so its mask is 0xF7C. A port number of 4 or more is not accepted.
- R11: Writing 1 to bit 0 of 0x10 returns every register to its reset value at that edge. It pulses eng_rst high for the following cycle. Address 0x10 always reads zero.
- R12: The descriptor base at 0x20 keeps 32 bits and the descriptor length at 0x24 keeps 16 bits. Addresses that are not mapped read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ch_evt | input | 120 | Six status events per channel |
| ch_on | output | 20 | Channel enable to the datapath |
| ch_rst | output | 20 | Channel reset in progress |
| ch_tx | output | 20 | Channel is transmit direction |
| ch_weight | output | 40 | Arbitration weight, two bits per channel |
| eng_rst | output | 1 | One-cycle engine reset pulse |
| irq | output | 1 | Combined interrupt |

## Verification
Every write lands at the clock edge under its strobe. Read data follows the address in the same cycle. So a value written is due on the bus one cycle after the write, and a status event shows on irq one cycle after it is presented. The bench's driver sets an address on a falling edge and queues the value expected for it. The monitor compares the value a fraction of a cycle later, before the next rising edge. Output checks for the channel reset are made on every falling edge after the write edge. They expect ch_rst high on the first eight of those edges and low on the ninth. The eng_rst pulse is checked on the single falling edge that follows the control write.

// File: rtl/dmacsr_bank.sv
module dmacsr_bank #(
  parameter int NUM_CH     = 20,
  parameter int NUM_PORT   = 4,
  parameter int HW_REV     = 3,
  parameter int RST_CYCLES = 8,
  parameter int DLEN_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [6*NUM_CH-1:0]   ch_evt,
  output logic [NUM_CH-1:0]     ch_on,
  output logic [NUM_CH-1:0]     ch_rst,
  output logic [NUM_CH-1:0]     ch_tx,
  output logic [2*NUM_CH-1:0]   ch_weight,
  output logic                  eng_rst,
  output logic                  irq
);
  localparam int SEL_W  = $clog2(NUM_CH);
  localparam int PSEL_W = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;
  localparam int CNT_W  = $clog2(RST_CYCLES + 1);
  localparam logic [31:0] ID_VAL = {12'(NUM_CH), 4'(NUM_PORT), 11'd0, 5'(HW_REV)};
  localparam logic [11:0] PC_MASK = 12'hF7C;

  localparam logic [7:0] A_ID = 8'h08, A_CTRL = 8'h10, A_POLL = 8'h14, A_CSEL = 8'h18,
                         A_CCTL = 8'h1C, A_DBA = 8'h20, A_DLEN = 8'h24, A_CIS = 8'h28,
                         A_CIE = 8'h2C, A_PSEL = 8'h40, A_PCTL = 8'h44, A_GIE = 8'hF4;

  logic [SEL_W-1:0]  csel;
  logic [PSEL_W-1:0] psel;
  logic [NUM_CH-1:0] on_q, rst_q, tx_q, pen_q, pdiv_q, gie_q;
  logic [1:0]        wt_q   [NUM_CH];
  logic [31:0]       dba_q  [NUM_CH];
  logic [DLEN_W-1:0] dlen_q [NUM_CH];
  logic [6:1]        sts_q  [NUM_CH];
  logic [6:1]        ie_q   [NUM_CH];
  logic [CNT_W-1:0]  cnt_q  [NUM_CH];
  logic [11:0]       pc_q   [NUM_PORT];
  logic              eng_q;

  wire glob_rst = bus_wr && bus_addr == A_CTRL && bus_wdata[0];

  function automatic logic wr_at(input logic [7:0] a);
    return bus_wr && bus_addr == a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_q <= 1'b0;
      csel  <= '0;
      psel  <= '0;
      on_q  <= '0; rst_q <= '0; tx_q <= '0; pen_q <= '0; pdiv_q <= '0; gie_q <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        wt_q[i] <= '0; dba_q[i] <= '0; dlen_q[i] <= '0;
        sts_q[i] <= '0; ie_q[i] <= '0; cnt_q[i] <= '0;
      end
      for (int p = 0; p < NUM_PORT; p++) pc_q[p] <= '0;
    end else if (glob_rst) begin
      eng_q <= 1'b1;
      csel  <= '0;
      psel  <= '0;
      on_q  <= '0; rst_q <= '0; tx_q <= '0; pen_q <= '0; pdiv_q <= '0; gie_q <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        wt_q[i] <= '0; dba_q[i] <= '0; dlen_q[i] <= '0;
        sts_q[i] <= '0; ie_q[i] <= '0; cnt_q[i] <= '0;
      end
      for (int p = 0; p < NUM_PORT; p++) pc_q[p] <= '0;
    end else begin
      eng_q <= 1'b0;
      if (wr_at(A_CSEL) && bus_wdata < 32'(NUM_CH)) csel <= bus_wdata[SEL_W-1:0];
      if (wr_at(A_PSEL) && bus_wdata < 32'(NUM_PORT)) psel <= bus_wdata[PSEL_W-1:0];
      if (wr_at(A_PCTL)) pc_q[psel] <= bus_wdata[11:0] & PC_MASK;
      if (wr_at(A_GIE)) gie_q <= bus_wdata[NUM_CH-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        logic sel_i, ctl_wr, start;
        logic [6:1] clr;
        sel_i  = (csel == SEL_W'(i));
        ctl_wr = sel_i && wr_at(A_CCTL);
        start  = ctl_wr && bus_wdata[1] && !rst_q[i];
        clr    = (sel_i && wr_at(A_CIS)) ? bus_wdata[6:1] : 6'd0;
        if (start) begin
          rst_q[i] <= 1'b1;
          cnt_q[i] <= CNT_W'(RST_CYCLES - 1);
        end else if (rst_q[i]) begin
          if (cnt_q[i] == '0) rst_q[i] <= 1'b0;
          else cnt_q[i] <= cnt_q[i] - 1'b1;
        end
        if (ctl_wr) begin
          tx_q[i] <= bus_wdata[8];
          wt_q[i] <= bus_wdata[17:16];
        end
        if (rst_q[i] || start) on_q[i] <= 1'b0;
        else if (ctl_wr) on_q[i] <= bus_wdata[0];
        if (rst_q[i] || start) sts_q[i] <= '0;
        else sts_q[i] <= (sts_q[i] & ~clr) | ch_evt[6*i +: 6];
        if (sel_i && wr_at(A_POLL)) begin
          pen_q[i]  <= bus_wdata[31];
          pdiv_q[i] <= bus_wdata[6];
        end
        if (sel_i && wr_at(A_DBA))  dba_q[i]  <= bus_wdata;
        if (sel_i && wr_at(A_DLEN)) dlen_q[i] <= bus_wdata[DLEN_W-1:0];
        if (sel_i && wr_at(A_CIE))  ie_q[i]   <= bus_wdata[6:1];
      end
    end
  end

  assign ch_on   = on_q;
  assign ch_rst  = rst_q;
  assign ch_tx   = tx_q;
  assign eng_rst = eng_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wt
    assign ch_weight[2*g +: 2] = wt_q[g];
  end

  always_comb begin
    irq = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      irq = irq | (gie_q[i] & |(sts_q[i] & ie_q[i]));
  end

  always_comb begin
    case (bus_addr)
      A_ID:    bus_rdata = ID_VAL;
      A_POLL:  bus_rdata = {pen_q[csel], 24'd0, pdiv_q[csel], 6'd0};
      A_CSEL:  bus_rdata = 32'(csel);
      A_CCTL:  bus_rdata = {14'd0, wt_q[csel], 7'd0, tx_q[csel], 6'd0, rst_q[csel], on_q[csel]};
      A_DBA:   bus_rdata = dba_q[csel];
      A_DLEN:  bus_rdata = 32'(dlen_q[csel]);
      A_CIS:   bus_rdata = {25'd0, sts_q[csel], 1'b0};
      A_CIE:   bus_rdata = {25'd0, ie_q[csel], 1'b0};
      A_PSEL:  bus_rdata = 32'(psel);
      A_PCTL:  bus_rdata = {20'd0, pc_q[psel]};
      A_GIE:   bus_rdata = 32'(gie_q);
      default: bus_rdata = 32'd0;
    endcase
  end

  // R3
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n) csel < SEL_W'(NUM_CH));
  // R6
  rst_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n) (ch_rst & ch_on) == '0);
  // R8
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) (gie_q == '0) |-> !irq);
  // R11
  eng_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                      eng_rst |-> (ch_on == '0 && ch_rst == '0 && !irq));
endmodule

// File: tb/dmacsr_bank_bench.sv
module dmacsr_bank_bench;
  localparam int NCH = 20;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [6*NCH-1:0] ch_evt = '0;
  logic [NCH-1:0] ch_on, ch_rst, ch_tx;
  logic [2*NCH-1:0] ch_weight;
  logic eng_rst, irq;
  int checks = 0, errors = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  event mon_ev;

  always #5 clk = ~clk;

  dmacsr_bank u_dmacsr_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_evt(ch_evt),
    .ch_on(ch_on), .ch_rst(ch_rst), .ch_tx(ch_tx), .ch_weight(ch_weight),
    .eng_rst(eng_rst), .irq(irq));

  always begin
    item_t it;
    @(mon_ev);
    #1;
    it = sbq.pop_front();
    checks++;
    if (bus_rdata !== it.exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.exp);
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    -> mon_ev;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  task automatic pulse(input int b1, input int b2);
    @(negedge clk);
    ch_evt[b1] = 1; ch_evt[b2] = 1;
    @(negedge clk);
    ch_evt = '0;
  endtask

  task automatic finish_sim();
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 ch_on", 32'(ch_on), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(8'h1C, 0, "R1 cctrl");
    rd(8'h20, 0, "R1 dbase");
    rd(8'hF4, 0, "R1 gie");
    // R2
    rd(8'h08, 32'h01440003, "R2 id");
    // R3 banking
    wr(8'h18, 2);  wr(8'h20, 32'hA5A50000);
    wr(8'h18, 7);  wr(8'h20, 32'h12345678);
    rd(8'h20, 32'h12345678, "R3 ch7 dbase");
    wr(8'h18, 2);
    rd(8'h20, 32'hA5A50000, "R3 ch2 dbase");
    wr(8'h18, 25);
    rd(8'h18, 2, "R3 bad select ignored");
    // R12
    wr(8'h24, 32'hFFFF1234);
    rd(8'h24, 32'h00001234, "R12 dlen width");
    rd(8'h30, 0, "R12 unmapped 0x30");
    rd(8'h04, 0, "R12 unmapped 0x04");
    // R4
    wr(8'h1C, 32'h00030101);
    rd(8'h1C, 32'h00030101, "R4 cctrl readback");
    chk("R4 ch_on", 32'(ch_on[2]), 1);
    chk("R4 ch_tx", 32'(ch_tx[2]), 1);
    chk("R4 weight", 32'(ch_weight[5:4]), 3);
    // R9
    wr(8'h14, 32'hFFFFFFFF);
    rd(8'h14, 32'h80000040, "R9 poll mask");
    // R5 / R6
    wr(8'h1C, 32'h00000003);
    for (int k = 0; k < 8; k++) begin
      chk("R5 ch_rst high", 32'(ch_rst[2]), 1);
      chk("R6 ch_on low", 32'(ch_on[2]), 0);
      if (k == 2) ch_evt[14] = 1;
      if (k == 3) ch_evt = '0;
      @(negedge clk);
    end
    chk("R5 ch_rst cleared", 32'(ch_rst[2]), 0);
    rd(8'h1C, 0, "R5 cctrl after reset");
    rd(8'h28, 0, "R6 events ignored in reset");
    // R7
    pulse(14, 12);
    rd(8'h28, 32'h0A, "R7 status set");
    wr(8'h28, 32'h08);
    rd(8'h28, 32'h02, "R7 w1c single");
    wr(8'h28, 32'h7E);
    rd(8'h28, 0, "R7 ack all");
    // R8
    wr(8'h2C, 32'h08);
    wr(8'hF4, 32'h4);
    pulse(14, 14);
    chk("R8 irq on", 32'(irq), 1);
    wr(8'hF4, 0);
    chk("R8 irq gated", 32'(irq), 0);
    wr(8'hF4, 32'h4);
    chk("R8 irq reenabled", 32'(irq), 1);
    wr(8'h28, 32'h7E);
    chk("R8 irq after ack", 32'(irq), 0);
    // R10
    wr(8'h40, 1);
    wr(8'h44, 32'hFFFFFFFF);
    rd(8'h44, 32'h00000F7C, "R10 port1 mask");
    wr(8'h40, 0);
    rd(8'h44, 0, "R10 port0 separate");
    wr(8'h40, 9);
    rd(8'h40, 0, "R10 bad port ignored");
    // R11
    wr(8'h18, 2); wr(8'h1C, 1); wr(8'hF4, 32'h4);
    wr(8'h10, 1);
    chk("R11 eng_rst pulse", 32'(eng_rst), 1);
    chk("R11 ch_on cleared", 32'(ch_on), 0);
    @(negedge clk);
    chk("R11 eng_rst one cycle", 32'(eng_rst), 0);
    rd(8'h10, 0, "R11 ctrl reads zero");
    rd(8'hF4, 0, "R11 gie cleared");
    rd(8'h18, 0, "R11 select cleared");
    wr(8'h18, 2);
    rd(8'h20, 0, "R11 ch2 dbase cleared");
    finish_sim();
  end
endmodule